// File: doc/BRIEF.md
# Pin Level Filter with Edge Event Strobe

This block conditions a raw, asynchronous external pin so that a timer or interrupt controller can use it as an event source. The pin is first brought into the clock domain by a two-stage synchronizer. The synchronized level can then pass through a noise filter. The filter takes samples on a selectable sampling tick and moves its output level only after three consecutive samples agree on a new value. The filter can also be bypassed.

An edge detector watches the filtered level and raises a one-clock event strobe on the edge kind chosen by a polarity field: rising, falling or both. The fourth polarity code is reserved and produces no events. Software must still treat a reconfiguration as a moment when a stale event may appear, and should clear any latched flag downstream after changing the filter or polarity fields.

Top module: `pin_event_filter`

## Requirements
- R1: The pin passes through a two-flop synchronizer. With filtering bypassed, `level_o` takes a new pin value on the third rising clock edge after the pin changes. With sampling every clock, it takes the new value on the fifth edge.
- R2: `filt_sel_i` selects the filter. 2'b00 bypasses the filter, and `level_o` follows the synchronized pin every clock. 2'b01 samples every clock, 2'b10 samples once every 8 clocks and 2'b11 samples once every 32 clocks.
- R3: In a sampling mode, `level_o` changes only when three consecutive sampling ticks see the same new value. A pin pulse that lasts one or two sampling periods is rejected, and a pulse of three or more periods is accepted.
- R4: `edge_pol_i` selects the event edge: 2'b00 rising, 2'b01 falling, 2'b10 both. A pulse that the filter accepts yields exactly one event under rising or falling, and exactly two under both.
- R5: With `edge_pol_i` = 2'b11, `event_o` never goes high, while `level_o` still tracks the filtered pin.
- R6: `event_o` is high for exactly one clock. It goes high in the cycle where `level_o` differs from its value on the previous clock.
- R7: While `rst_n` is low, the filtered level, its previous-cycle copy and the sample history are cleared to 0. `level_o` and `event_o` are then 0, and no edge is reported on the first clock after reset.
- R8: With the filter bypassed, a pin pulse of one or more clocks reaches `level_o` and produces the selected events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_i | input | 1 | Raw asynchronous pin |
| filt_sel_i | input | 2 | Filter select: bypass / every clock / every 8 / every 32 |
| edge_pol_i | input | 2 | Event edge: rising / falling / both / none |
| level_o | output | 1 | Filtered pin level |
| event_o | output | 1 | One-clock event strobe |

## Verification
The bench sweeps every filter code against every polarity code, using pulses of one to four sampling periods. Each pulse width is an exact multiple of the sampling period, so the number of ticks that fall inside the pulse is known.

A filter that accepted two matching samples instead of three would let the two-period glitch through and report an event that should not exist. A wrong divider would shift the acceptance boundary to a different pulse width. A both-edges mode that only saw one edge would report one event instead of two. A reserved code that decoded as some edge kind would report events where none are expected. Exact-edge latency checks in bypass mode and in every-clock mode catch a synchronizer or vote stage that is one register too long or too short.

// File: rtl/pin_filt_pkg.sv
// Shared encodings for the pin filter and edge detector.
// Assumes: the codes match the 2-bit fields seen at the top-level ports.
package pin_filt_pkg;

    typedef enum logic [1:0] {
        FS_BYPASS   = 2'b00,
        FS_EVERY    = 2'b01,
        FS_DIV_MID  = 2'b10,
        FS_DIV_SLOW = 2'b11
    } filt_sel_e;

    typedef enum logic [1:0] {
        EP_RISE = 2'b00,
        EP_FALL = 2'b01,
        EP_BOTH = 2'b10,
        EP_NONE = 2'b11
    } edge_pol_e;

endpackage

// File: rtl/pinfilt_sync.sv
// Multi-flop synchronizer for an asynchronous pin.
// Assumes: STAGES >= 2; the output is delayed by STAGES clocks and is reset low.
module pinfilt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pinfilt_tick.sv
// Sampling tick generator for the filter.
// Assumes: DIV_MID and DIV_SLOW are powers of two with DIV_MID <= DIV_SLOW.
// A single free-running counter serves both dividers.
module pinfilt_tick
    import pin_filt_pkg::*;
#(
    parameter int DIV_MID  = 8,
    parameter int DIV_SLOW = 32
) (
    input  logic      clk,
    input  logic      rst_n,
    input  filt_sel_e sel_i,
    output logic      tick_o
);
    localparam int CW    = $clog2(DIV_SLOW);
    localparam int MID_W = $clog2(DIV_MID);

    logic [CW-1:0] cnt_q;

    // Free-running divider counter.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    // Pick the tick rate for the selected filter mode.
    always_comb begin
        unique case (sel_i)
            FS_BYPASS:   tick_o = 1'b0;
            FS_EVERY:    tick_o = 1'b1;
            FS_DIV_MID:  tick_o = &cnt_q[MID_W-1:0];
            FS_DIV_SLOW: tick_o = &cnt_q;
            default:     tick_o = 1'b0;
        endcase
    end

    // In slow mode, two ticks never fall on adjacent clocks.
    assert_slow_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == FS_DIV_SLOW && tick_o) |=> (!tick_o || sel_i != FS_DIV_SLOW));
endmodule

// File: rtl/pinfilt_vote.sv
// Majority-free agreement filter: the level moves only after MATCH equal samples.
// Assumes: MATCH >= 2; in bypass the level copies the input every clock.
module pinfilt_vote #(
    parameter int MATCH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bypass_i,
    input  logic tick_i,
    input  logic samp_i,
    output logic level_o
);
    logic [MATCH-2:0] hist_q;
    logic [MATCH-1:0] window;
    logic             lvl_q;

    assign window = {hist_q, samp_i};

    // Update the sample history and accept a new level on full agreement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
            lvl_q  <= 1'b0;
        end else if (bypass_i) begin
            hist_q <= window[MATCH-2:0];
            lvl_q  <= samp_i;
        end else if (tick_i) begin
            hist_q <= window[MATCH-2:0];
            if (&window)       lvl_q <= 1'b1;
            else if (~|window) lvl_q <= 1'b0;
        end
    end

    assign level_o = lvl_q;

    // Between sampling ticks, the filtered level holds.
    assert_hold_between_ticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass_i && !tick_i) |=> $stable(lvl_q));

    // Reset clears the level.
    assert_reset_low_R7: assert property (@(posedge clk)
        (!rst_n) |=> !lvl_q);
endmodule

// File: rtl/pinfilt_edge.sv
// Edge detector on the filtered level, producing a one-clock strobe.
// Assumes: the previous-cycle copy resets low together with the level.
module pinfilt_edge
    import pin_filt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      level_i,
    input  edge_pol_e pol_i,
    output logic      event_o
);
    logic prev_q;
    logic rise, fall;

    // Remember the level of the previous clock.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level_i;
    end

    assign rise = level_i & ~prev_q;
    assign fall = ~level_i & prev_q;

    // Map the detected edges onto the selected polarity.
    always_comb begin
        unique case (pol_i)
            EP_RISE: event_o = rise;
            EP_FALL: event_o = fall;
            EP_BOTH: event_o = rise | fall;
            default: event_o = 1'b0;
        endcase
    end

    // A single-edge mode never strobes on two adjacent clocks.
    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (event_o && pol_i != EP_BOTH && $stable(pol_i)) |=> !event_o);

    // The reserved code is silent.
    assert_reserved_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pol_i == EP_NONE) |-> !event_o);
endmodule

// File: rtl/pin_event_filter.sv
// Top: synchronizer, sampling tick, agreement filter and edge detector.
// Assumes: configuration fields change only while the pin is quiet; a stale
// event after reconfiguration is the consumer's to clear.
module pin_event_filter
    import pin_filt_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MATCH       = 3,
    parameter int DIV_MID     = 8,
    parameter int DIV_SLOW    = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  logic [1:0] filt_sel_i,
    input  logic [1:0] edge_pol_i,
    output logic       level_o,
    output logic       event_o
);
    filt_sel_e sel;
    edge_pol_e pol;
    logic      pin_sync;
    logic      tick;
    logic      lvl;

    assign sel = filt_sel_e'(filt_sel_i);
    assign pol = edge_pol_e'(edge_pol_i);

    pinfilt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_sync)
    );

    pinfilt_tick #(.DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) u_tick (
        .clk(clk), .rst_n(rst_n), .sel_i(sel), .tick_o(tick)
    );

    pinfilt_vote #(.MATCH(MATCH)) u_vote (
        .clk(clk), .rst_n(rst_n), .bypass_i(sel == FS_BYPASS),
        .tick_i(tick), .samp_i(pin_sync), .level_o(lvl)
    );

    pinfilt_edge u_edge (
        .clk(clk), .rst_n(rst_n), .level_i(lvl), .pol_i(pol), .event_o(event_o)
    );

    assign level_o = lvl;
endmodule

// File: tb/pin_event_filter_tb.sv
module pin_event_filter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_i = 1'b0;
    logic [1:0] filt_sel_i = 2'b00;
    logic [1:0] edge_pol_i = 2'b00;
    logic       level_o, event_o;

    int checks = 0;
    int errors = 0;
    int ev_cnt = 0;
    bit lvl_seen = 0;
    bit counting = 0;

    always #4 clk = ~clk;  // 125 MHz

    pin_event_filter dut_i (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
        .filt_sel_i(filt_sel_i), .edge_pol_i(edge_pol_i),
        .level_o(level_o), .event_o(event_o)
    );

    // Observe outputs away from the active edge.
    always @(negedge clk) begin
        if (counting) begin
            if (event_o) ev_cnt++;
            if (level_o) lvl_seen = 1;
        end
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int period(input int sel);
        case (sel)
            1: return 1;
            2: return 8;
            3: return 32;
            default: return 1;
        endcase
    endfunction

    // One pulse of w sampling periods under a given filter and polarity.
    task automatic trial(input int sel, input int pol, input int w);
        int  exp_ev;
        bit  accept;
        @(negedge clk);
        filt_sel_i = sel[1:0];
        edge_pol_i = pol[1:0];
        repeat (150) @(negedge clk);
        ev_cnt = 0; lvl_seen = 0; counting = 1;
        pin_i = 1'b1;
        repeat (w * period(sel)) @(negedge clk);
        pin_i = 1'b0;
        repeat (150) @(negedge clk);
        counting = 0;
        accept = (sel == 0) || (w >= 3);
        case (pol)
            0, 1:    exp_ev = accept ? 1 : 0;
            2:       exp_ev = accept ? 2 : 0;
            default: exp_ev = 0;
        endcase
        // R3 / R8: acceptance of the pulse; R4 / R5: event count per polarity.
        check(sel == 0 ? "R8" : "R3", int'(lvl_seen), int'(accept),
              $sformatf("level reached sel=%0d pol=%0d w=%0d", sel, pol, w));
        check(pol == 3 ? "R5" : "R4", ev_cnt, exp_ev,
              $sformatf("events sel=%0d pol=%0d w=%0d", sel, pol, w));
    endtask

    // Exact latency of a rising edge; lat = edge count until level changes.
    task automatic latency(input int sel, input int lat, input string req);
        @(negedge clk);
        filt_sel_i = sel[1:0];
        edge_pol_i = 2'b00;
        repeat (100) @(negedge clk);
        pin_i = 1'b1;
        for (int i = 1; i <= lat + 2; i++) begin
            @(negedge clk);
            check(req, int'(level_o), int'(i >= lat), $sformatf("level edge %0d sel=%0d", i, sel));
            check("R6", int'(event_o), int'(i == lat), $sformatf("event edge %0d sel=%0d", i, sel));
        end
        pin_i = 1'b0;
        repeat (100) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired, run incomplete (R1)");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        pin_i = 1'b0;
        repeat (4) @(negedge clk);
        check("R7", int'(level_o), 0, "level in reset");
        check("R7", int'(event_o), 0, "event in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R7", int'(level_o), 0, "level after reset");
        check("R7", int'(event_o), 0, "event after reset");

        latency(0, 3, "R1");
        latency(1, 5, "R1");

        for (int s = 0; s < 4; s++)
            for (int p = 0; p < 4; p++)
                for (int w = 1; w <= 4; w++)
                    trial(s, p, w);

        // R2: slow-mode pulse of 2 periods plus one sample is still rejected
        // only if shorter than three periods; 3 periods of mid rate is 24 clocks,
        // which must be rejected at the slow rate.
        @(negedge clk);
        filt_sel_i = 2'b11; edge_pol_i = 2'b10;
        repeat (150) @(negedge clk);
        ev_cnt = 0; lvl_seen = 0; counting = 1;
        pin_i = 1'b1; repeat (24) @(negedge clk); pin_i = 1'b0;
        repeat (150) @(negedge clk);
        counting = 0;
        check("R2", ev_cnt, 0, "24-clock pulse at slow rate");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule